// File: doc/BRIEF.md
# Dual framebuffer scanout address sequencer

This block produces the read addresses a display controller's DMA uses to fetch pixel data from memory. It scans two framebuffer windows in strict alternation. Each window is described by a live base address and a live ceiling address. One frame is fetched from window 0, the next from window 1, then window 0 again, and so on. The block issues one bus word address per accepted request. A window is finished when the next word would reach its ceiling, and fetching then continues at the other window's base.

Software gives a new image position as a buffer address, a plane offset, x and y offsets, a line pitch, bytes per pixel and a visible line count. The block computes the start and end byte addresses from these values. The live registers are not touched directly while the raster runs. Instead the new pair goes into a shadow copy and both windows are marked stale. Each window takes the shadow pair only when its own frame ends, so a page flip never tears. While the raster is off, an update lands in both live windows at once.

Each update made while the raster runs counts as a flip request. A done pulse marks the first frame end after such a request. Only one request may be outstanding at a time, and a further request is refused with a busy pulse.

Top module: `scan_dual_fb_seq`

## Requirements
- R1: The start byte address of an update is buf + plane_off + y*pitch + x*bpp, modulo 2^ADDR_W. The first word fetched after the raster is enabled is start >> log2(WORD_BYTES).
- R2: The end (ceiling) byte address is start + lines*pitch. A window holds (end-start)/WORD_BYTES words when that span is a whole number of words.
- R3: An update accepted while raster_en is high changes only the shadow pair and marks both windows stale. Words already in flight keep coming from the old live pair.
- R4: At the end of frame of window n, a stale window n loads its live pair from the shadow and becomes clean. The other window keeps its old live pair until its own frame end.
- R5: An update accepted while raster_en is low writes both live pairs at once and leaves both windows clean.
- R6: fetch_valid rises the cycle after raster_en is high and is low the cycle after raster_en is low. fetch_addr advances by one word per cycle with fetch_valid and fetch_ready both high, and holds otherwise.
- R7: After raster enable the first window is window 0. When the word after an accepted word would reach the window's ceiling, the next fetch_addr is the other window's base.
- R8: Bit n of eof_flag (bit 0 = window 0, bit 1 = window 1) is sticky. It is set in the cycle after the last word of window n is accepted and cleared by a one on bit n of eof_clr. A set in the same cycle wins over the clear.
- R9: flip_done is a one-cycle pulse. It rises together with the eof_flag set of the first frame end after an update accepted with raster_en high, and that frame end releases the pending request.
- R10: An update presented while a request is pending is ignored and raises upd_busy for one cycle in the following cycle.
- R11: After reset fetch_valid, eof_flag, flip_done and upd_busy are zero, no request is pending and both windows are clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_en | input | 1 | Raster running; selects shadowed or direct updates |
| upd_valid | input | 1 | Address update request, one cycle |
| upd_buf_addr | input | ADDR_W | Buffer byte address |
| upd_plane_off | input | ADDR_W | Plane byte offset |
| upd_x | input | COORD_W | Horizontal pixel offset |
| upd_y | input | COORD_W | Vertical line offset |
| upd_pitch | input | PITCH_W | Line pitch in bytes |
| upd_bpp | input | BPP_W | Bytes per pixel |
| upd_lines | input | COORD_W | Visible line count |
| upd_busy | output | 1 | Pulse: the previous update was refused |
| fetch_ready | input | 1 | Bus accepts the current word address |
| fetch_valid | output | 1 | Word address valid |
| fetch_addr | output | ADDR_W-log2(WORD_BYTES) | Word address |
| eof_clr | input | 2 | Write-one-to-clear for eof_flag |
| eof_flag | output | 2 | Sticky end-of-frame flag per window |
| flip_done | output | 1 | Pulse: first frame end after a flip request |

## Verification
The address formula is tried with four position sets: zero offsets, all terms non-zero, an odd bytes-per-pixel value, and a two-word window. This separates a dropped or swapped term in the start address from an error in the span. The word count up to the end-of-frame flag exposes ceiling compare mistakes of one word. A flip sequence issues an update in the middle of a frame, followed by a second update while the first is pending. The resulting address stream shows the old pair in both windows before each window switches at its own frame end. This tells per-window reloading apart from reloading both at the first frame end. It also shows that the refused update never appears. Stalls with fetch_ready low and a one-bit flag clear cover the hold and clear behaviour.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int NUM_WIN = 2;
  typedef enum logic {WIN_0 = 1'b0, WIN_1 = 1'b1} win_e;
endpackage

// File: rtl/scan_addr_calc.sv
module scan_addr_calc #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12,
  parameter int PITCH_W = 16,
  parameter int BPP_W   = 3
) (
  input  logic [ADDR_W-1:0]  buf_addr,
  input  logic [ADDR_W-1:0]  plane_off,
  input  logic [COORD_W-1:0] x_off,
  input  logic [COORD_W-1:0] y_off,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [BPP_W-1:0]   bpp,
  input  logic [COORD_W-1:0] lines,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  end_addr
);
  logic [ADDR_W-1:0] row_bytes, col_bytes, span_bytes;

  always_comb begin
    row_bytes  = ADDR_W'(y_off) * ADDR_W'(pitch);
    col_bytes  = ADDR_W'(x_off) * ADDR_W'(bpp);
    span_bytes = ADDR_W'(lines) * ADDR_W'(pitch);
    start_addr = buf_addr + plane_off + row_bytes + col_bytes;
    end_addr   = start_addr + span_bytes;
  end
endmodule

// File: rtl/scan_window_bank.sv
module scan_window_bank
  import scan_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             direct_wr,
  input  logic                             shadow_wr,
  input  logic [ADDR_W-1:0]                new_base,
  input  logic [ADDR_W-1:0]                new_ceil,
  input  logic [NUM_WIN-1:0]               eof_evt,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   live_base,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   live_ceil
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] base_q, base_d, ceil_q, ceil_d;
    logic [ADDR_W-1:0] shd_base_q, shd_base_d, shd_ceil_q, shd_ceil_d;
    logic              stale_q, stale_d;

    always_comb begin
      base_d     = base_q;
      ceil_d     = ceil_q;
      shd_base_d = shd_base_q;
      shd_ceil_d = shd_ceil_q;
      stale_d    = stale_q;
      if (direct_wr) begin
        base_d     = new_base;
        ceil_d     = new_ceil;
        shd_base_d = new_base;
        shd_ceil_d = new_ceil;
        stale_d    = 1'b0;
      end else begin
        if (eof_evt[w] && stale_q) begin
          base_d  = shd_base_q;
          ceil_d  = shd_ceil_q;
          stale_d = 1'b0;
        end
        if (shadow_wr) begin
          shd_base_d = new_base;
          shd_ceil_d = new_ceil;
          stale_d    = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q     <= '0;
        ceil_q     <= '0;
        shd_base_q <= '0;
        shd_ceil_q <= '0;
        stale_q    <= 1'b0;
      end else begin
        base_q     <= base_d;
        ceil_q     <= ceil_d;
        shd_base_q <= shd_base_d;
        shd_ceil_q <= shd_ceil_d;
        stale_q    <= stale_d;
      end
    end

    assign live_base[w] = base_q;
    assign live_ceil[w] = ceil_q;
  end
endmodule

// File: rtl/scan_fetch_ctrl.sv
module scan_fetch_ctrl
  import scan_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           raster_en,
  input  logic                           fetch_ready,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] live_base,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] live_ceil,
  output logic                           fetch_valid,
  output logic [ADDR_W-1:0]              cur_addr,
  output logic [NUM_WIN-1:0]             eof_evt
);
  logic              run_q, run_d;
  win_e              act_q, act_d, other;
  logic [ADDR_W-1:0] cur_q, cur_d, next_word;

  always_comb begin
    run_d     = raster_en;
    act_d     = act_q;
    cur_d     = cur_q;
    eof_evt   = '0;
    other     = (act_q == WIN_0) ? WIN_1 : WIN_0;
    next_word = cur_q + ADDR_W'(WORD_BYTES);
    if (!run_q) begin
      act_d = WIN_0;
      cur_d = live_base[WIN_0];
    end else if (fetch_ready) begin
      if (next_word >= live_ceil[act_q]) begin
        eof_evt[act_q] = 1'b1;
        act_d          = other;
        cur_d          = live_base[other];
      end else begin
        cur_d = next_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= WIN_0;
      cur_q <= '0;
    end else begin
      run_q <= run_d;
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  assign fetch_valid = run_q;
  assign cur_addr    = cur_q;
endmodule

// File: rtl/scan_flip_track.sv
module scan_flip_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_valid,
  input  logic raster_en,
  input  logic frame_end,
  output logic direct_wr,
  output logic shadow_wr,
  output logic flip_done,
  output logic upd_busy
);
  logic pend_q, pend_d, done_q, done_d, busy_q, busy_d;
  logic take;

  always_comb begin
    take      = upd_valid && !pend_q;
    direct_wr = take && !raster_en;
    shadow_wr = take && raster_en;
    pend_d    = pend_q;
    if (shadow_wr)      pend_d = 1'b1;
    else if (frame_end) pend_d = 1'b0;
    done_d = pend_q && frame_end;
    busy_d = upd_valid && pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      busy_q <= busy_d;
    end
  end

  assign flip_done = done_q;
  assign upd_busy  = busy_q;
endmodule

// File: rtl/scan_dual_fb_seq.sv
module scan_dual_fb_seq
  import scan_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int COORD_W    = 12,
  parameter int PITCH_W    = 16,
  parameter int BPP_W      = 3,
  parameter int WORD_BYTES = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  raster_en,
  input  logic                                  upd_valid,
  input  logic [ADDR_W-1:0]                     upd_buf_addr,
  input  logic [ADDR_W-1:0]                     upd_plane_off,
  input  logic [COORD_W-1:0]                    upd_x,
  input  logic [COORD_W-1:0]                    upd_y,
  input  logic [PITCH_W-1:0]                    upd_pitch,
  input  logic [BPP_W-1:0]                      upd_bpp,
  input  logic [COORD_W-1:0]                    upd_lines,
  output logic                                  upd_busy,
  input  logic                                  fetch_ready,
  output logic                                  fetch_valid,
  output logic [ADDR_W-$clog2(WORD_BYTES)-1:0]  fetch_addr,
  input  logic [1:0]                            eof_clr,
  output logic [1:0]                            eof_flag,
  output logic                                  flip_done
);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam int FA_W       = ADDR_W - WORD_SHIFT;

  logic [1:0]                     rst_sync_q;
  logic                           rst_int_n;
  logic [ADDR_W-1:0]              calc_start, calc_end, cur_addr;
  logic [NUM_WIN-1:0][ADDR_W-1:0] live_base, live_ceil;
  logic [NUM_WIN-1:0]             eof_evt;
  logic                           direct_wr, shadow_wr;
  logic [1:0]                     flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scan_addr_calc #(
    .ADDR_W(ADDR_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W)
  ) u_calc (
    .buf_addr  (upd_buf_addr),
    .plane_off (upd_plane_off),
    .x_off     (upd_x),
    .y_off     (upd_y),
    .pitch     (upd_pitch),
    .bpp       (upd_bpp),
    .lines     (upd_lines),
    .start_addr(calc_start),
    .end_addr  (calc_end)
  );

  scan_flip_track u_flip (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_valid(upd_valid),
    .raster_en(raster_en),
    .frame_end(|eof_evt),
    .direct_wr(direct_wr),
    .shadow_wr(shadow_wr),
    .flip_done(flip_done),
    .upd_busy (upd_busy)
  );

  scan_window_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .direct_wr(direct_wr),
    .shadow_wr(shadow_wr),
    .new_base (calc_start),
    .new_ceil (calc_end),
    .eof_evt  (eof_evt),
    .live_base(live_base),
    .live_ceil(live_ceil)
  );

  scan_fetch_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .raster_en  (raster_en),
    .fetch_ready(fetch_ready),
    .live_base  (live_base),
    .live_ceil  (live_ceil),
    .fetch_valid(fetch_valid),
    .cur_addr   (cur_addr),
    .eof_evt    (eof_evt)
  );

  always_comb flag_d = (flag_q & ~eof_clr) | eof_evt;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flag_q <= 2'b00;
    else            flag_q <= flag_d;
  end

  assign eof_flag   = flag_q;
  assign fetch_addr = cur_addr[ADDR_W-1:WORD_SHIFT];
endmodule

// File: rtl/scan_dual_fb_seq_chk.sv
module scan_dual_fb_seq_chk #(
  parameter int FA_W = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            raster_en,
  input logic            upd_valid,
  input logic            upd_busy,
  input logic            fetch_ready,
  input logic            fetch_valid,
  input logic [FA_W-1:0] fetch_addr,
  input logic [1:0]      eof_clr,
  input logic [1:0]      eof_flag,
  input logic            flip_done
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (!fetch_valid || $stable(fetch_addr)));

  assert_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !raster_en |=> !fetch_valid);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eof_flag[0]) |-> $past(fetch_valid && fetch_ready));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_flag[1] && !eof_clr[1]) |=> eof_flag[1]);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |=> !flip_done);

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |-> $past(upd_valid));
endmodule

bind scan_dual_fb_seq scan_dual_fb_seq_chk #(.FA_W(FA_W)) i_chk (.*);

// File: tb/test_scan_dual_fb_seq.sv
module test_scan_dual_fb_seq;
  localparam int ADDR_W = 32;
  localparam int FA_W   = 29;

  typedef struct packed {
    logic [31:0] bufa;
    logic [31:0] off;
    logic [11:0] x;
    logic [11:0] y;
    logic [15:0] pitch;
    logic [2:0]  bpp;
    logic [11:0] lines;
    logic [31:0] st;
    logic [31:0] en;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h1000, 32'h0,   12'd0, 12'd0, 16'd64,  3'd2, 12'd4, 32'h1000, 32'h1100},
    '{32'h2000, 32'h40,  12'd4, 12'd2, 16'd32,  3'd4, 12'd3, 32'h2090, 32'h20F0},
    '{32'h8000, 32'h100, 12'd8, 12'd5, 16'd128, 3'd3, 12'd1, 32'h8398, 32'h8418},
    '{32'h0,    32'h8,   12'd2, 12'd0, 16'd16,  3'd4, 12'd1, 32'h10,   32'h20}
  };

  logic clk = 1'b0;
  logic rst_n, raster_en, upd_valid, fetch_ready;
  logic [31:0] upd_buf_addr, upd_plane_off;
  logic [11:0] upd_x, upd_y, upd_lines;
  logic [15:0] upd_pitch;
  logic [2:0]  upd_bpp;
  logic [1:0]  eof_clr;
  logic        upd_busy, fetch_valid, flip_done;
  logic [FA_W-1:0] fetch_addr;
  logic [1:0]  eof_flag;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scan_dual_fb_seq i_scan_dual_fb_seq (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .upd_valid(upd_valid),
    .upd_buf_addr(upd_buf_addr), .upd_plane_off(upd_plane_off),
    .upd_x(upd_x), .upd_y(upd_y), .upd_pitch(upd_pitch), .upd_bpp(upd_bpp),
    .upd_lines(upd_lines), .upd_busy(upd_busy), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .eof_clr(eof_clr),
    .eof_flag(eof_flag), .flip_done(flip_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_upd(input logic [31:0] b, input logic [31:0] o, input logic [11:0] x,
                          input logic [11:0] y, input logic [15:0] p, input logic [2:0] bp,
                          input logic [11:0] l);
    upd_buf_addr = b; upd_plane_off = o; upd_x = x; upd_y = y;
    upd_pitch = p; upd_bpp = bp; upd_lines = l; upd_valid = 1'b1;
    step();
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [FA_W-1:0] exp_seq [8];
    int n;
    rst_n = 1'b0; raster_en = 1'b0; upd_valid = 1'b0; fetch_ready = 1'b0;
    eof_clr = 2'b00; upd_buf_addr = '0; upd_plane_off = '0; upd_x = '0;
    upd_y = '0; upd_pitch = '0; upd_bpp = '0; upd_lines = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R11: reset state
    chk(fetch_valid == 1'b0, "R11 fetch_valid", fetch_valid, 0);
    chk(eof_flag == 2'b00, "R11 eof_flag", eof_flag, 0);
    chk(flip_done == 1'b0, "R11 flip_done", flip_done, 0);
    chk(upd_busy == 1'b0, "R11 upd_busy", upd_busy, 0);

    // table walk: direct writes, address formula and window span
    for (int i = 0; i < 4; i++) begin
      raster_en = 1'b0;
      step(); step();
      send_upd(VECS[i].bufa, VECS[i].off, VECS[i].x, VECS[i].y,
               VECS[i].pitch, VECS[i].bpp, VECS[i].lines);
      chk(upd_busy == 1'b0, "R5 direct accepted", upd_busy, 0);
      eof_clr = 2'b11; step(); eof_clr = 2'b00;
      raster_en = 1'b1; step();
      chk(fetch_valid == 1'b1, "R6 valid after enable", fetch_valid, 1);
      chk(fetch_addr == FA_W'(VECS[i].st >> 3), "R1 start word", fetch_addr, VECS[i].st >> 3);
      fetch_ready = 1'b1;
      n = 0;
      while (!eof_flag[0] && n < 200) begin
        if (fetch_valid) n++;
        step();
      end
      fetch_ready = 1'b0;
      chk(n == int'((VECS[i].en - VECS[i].st) >> 3), "R2 words per window", n, (VECS[i].en - VECS[i].st) >> 3);
      chk(fetch_addr == FA_W'(VECS[i].st >> 3), "R7 switch to window 1 base", fetch_addr, VECS[i].st >> 3);
      chk(eof_flag == 2'b01, "R8 window 0 flag only", eof_flag, 2'b01);
    end

    // flip sequence: A live, B shadowed mid-frame, C refused
    raster_en = 1'b0; step(); step();
    send_upd(32'h10, 32'h0, 12'd0, 12'd0, 16'd16, 3'd1, 12'd1);
    eof_clr = 2'b11; step(); eof_clr = 2'b00;
    raster_en = 1'b1; step();
    chk(fetch_addr == FA_W'(2), "R7 first window is 0", fetch_addr, 2);
    send_upd(32'h400, 32'h0, 12'd0, 12'd0, 16'd16, 3'd1, 12'd1);
    chk(upd_busy == 1'b0, "R3 shadow update accepted", upd_busy, 0);
    chk(fetch_addr == FA_W'(2), "R6 hold while not ready", fetch_addr, 2);
    send_upd(32'h800, 32'h0, 12'd0, 12'd0, 16'd16, 3'd1, 12'd1);
    chk(upd_busy == 1'b1, "R10 busy on second request", upd_busy, 1);
    step();
    chk(upd_busy == 1'b0, "R10 busy is one cycle", upd_busy, 0);
    exp_seq = '{FA_W'(2), FA_W'(3), FA_W'(2), FA_W'(3),
                FA_W'(128), FA_W'(129), FA_W'(128), FA_W'(129)};
    fetch_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      // k 0..1: R3 old pair; k 2..3: R4 window 1 still old; k 4..7: new pair, C never seen (R10)
      chk(fetch_addr == exp_seq[k], (k < 4) ? "R4 old pair kept" : "R4 reload at own frame end",
          fetch_addr, exp_seq[k]);
      chk(flip_done == (k == 2), "R9 done pulse timing", flip_done, (k == 2));
      if (k == 1) chk(eof_flag == 2'b00, "R8 not yet set", eof_flag, 0);
      if (k == 2) chk(eof_flag == 2'b01, "R8 set after last word", eof_flag, 2'b01);
      step();
    end
    fetch_ready = 1'b0;
    chk(eof_flag == 2'b11, "R8 both flags sticky", eof_flag, 2'b11);
    eof_clr = 2'b01; step(); eof_clr = 2'b00;
    chk(eof_flag == 2'b10, "R8 clear bit 0 only", eof_flag, 2'b10);
    send_upd(32'h40, 32'h0, 12'd0, 12'd0, 16'd16, 3'd1, 12'd1);
    chk(upd_busy == 1'b0, "R9 request released by frame end", upd_busy, 0);
    raster_en = 1'b0; step(); step();
    chk(fetch_valid == 1'b0, "R6 idle when disabled", fetch_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule